// File: doc/BRIEF.md
# SIMT Warp Launch Mask Generator

This block turns one data-parallel kernel launch into a stream of warp descriptors. A launch gives an element count and a thread-block size. The block walks the thread blocks in order and splits each block into 32-thread warps. For every warp it emits the block index, the warp index inside the block, the global index of lane 0, a 32-bit lane-enable mask and the core that owns the block.

Lanes whose global index is at or past the element count are switched off in the mask. A warp that would have no enabled lane is never emitted, so the tail of the final block produces no empty warps. Whole blocks go to cores in rotation. A downstream dispatcher takes the warps over a valid/ready pair. The caller sees a busy flag, which stays high until the last warp has been taken.

Top module: `simt_launch_gen`

## Requirements
- R1: The warps of a launch carry block indices 0 up to ceil(n / block size) - 1, and block index = floor(global base / block size).
- R2: Each warp's base index equals block index * block size + warp index * 32, and the warp index counts from 0 within each block.
- R3: Bit i of the mask is 1 exactly when base index + i < n (bit 0 is lane 0).
- R4: No warp with an all-zero mask is emitted. A launch with n = 0 emits no warp and leaves busy low.
- R5: The core number equals block index modulo the core count, so block 0 goes to core 0.
- R6: Warps leave in increasing global order. While valid is high and ready is low, every warp output holds its value.
- R7: A start is accepted only when the block size is a nonzero multiple of 32 and no more than 512. Any other block size sets the error flag in the next cycle and starts nothing. The next accepted start clears the flag.
- R8: A start raised while busy is ignored and does not change the warps of the launch in progress.
- R9: After an accepted start with n > 0, busy and valid are high in the next cycle with warp 0 on the outputs. Busy falls in the cycle after the last warp's transfer.
- R10: After reset, busy, valid and error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request |
| n_i | input | N_W | Element count |
| block_dim_i | input | BD_W | Threads per block |
| ready_i | input | 1 | Consumer takes the warp |
| busy_o | output | 1 | Launch in progress |
| err_o | output | 1 | Last start had an illegal block size |
| valid_o | output | 1 | Warp descriptor present |
| blk_idx_o | output | N_W | Block index |
| warp_idx_o | output | WI_W | Warp index within the block |
| base_idx_o | output | N_W | Global index of lane 0 |
| mask_o | output | 32 | Lane enable mask |
| core_o | output | CORE_W | Target core |

## Verification
The interesting case is the cycle where a block boundary meets a partial mask and a wrap of the core rotation. Here the warp index returns to zero while the block index and the core number both step forward. In the same transfer the launch may end. Launches whose block count is one more than the core count provoke this. The element count is chosen so it ends either exactly on a block edge or a few lanes into a new block, with ready stalls in between. Every emitted warp is compared against fields the bench computes from n and the block size. The bench also checks that busy falls right after the final transfer and that no empty warp follows.

// File: rtl/simt_launch_pkg.sv
package simt_launch_pkg;
  localparam int WARP_SZ = 32;
  localparam int LANE_W  = 5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } launch_st_e;
endpackage

// File: rtl/launch_cfg_check.sv
module launch_cfg_check
  import simt_launch_pkg::*;
#(
  parameter int MAX_BD = 512,
  parameter int BD_W   = $clog2(MAX_BD) + 1,
  parameter int WI_W   = $clog2(MAX_BD / WARP_SZ)
) (
  input  logic [BD_W-1:0] bd_i,
  output logic            ok_o,
  output logic [WI_W-1:0] wlast_o
);
  logic [BD_W-LANE_W-1:0] nwarp;

  assign nwarp   = bd_i[BD_W-1:LANE_W];
  assign ok_o    = (bd_i[LANE_W-1:0] == '0) && (bd_i != '0) && (bd_i <= BD_W'(MAX_BD));
  assign wlast_o = WI_W'(nwarp - 1'b1);
endmodule

// File: rtl/warp_mask_gen.sv
module warp_mask_gen
  import simt_launch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]   n_i,
  input  logic [CNT_W:0]     base_i,
  output logic [WARP_SZ-1:0] mask_o,
  output logic               last_o
);
  logic [CNT_W:0] rem;

  assign rem    = {1'b0, n_i} - base_i;
  assign last_o = rem <= (CNT_W+1)'(WARP_SZ);

  for (genvar i = 0; i < WARP_SZ; i++) begin : g_lane
    assign mask_o[i] = rem > (CNT_W+1)'(i);
  end
endmodule

// File: rtl/launch_walker.sv
module launch_walker
  import simt_launch_pkg::*;
#(
  parameter int N_W       = 16,
  parameter int WI_W      = 4,
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [WI_W-1:0]   wlast_i,
  output logic [N_W:0]      base_o,
  output logic [WI_W-1:0]   warp_o,
  output logic [N_W-1:0]    blk_o,
  output logic [CORE_W-1:0] core_o
);
  localparam logic [CORE_W-1:0] CORE_LAST = CORE_W'(NUM_CORES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      warp_o <= '0;
      blk_o  <= '0;
      core_o <= '0;
    end else if (load_i) begin
      base_o <= '0;
      warp_o <= '0;
      blk_o  <= '0;
      core_o <= '0;
    end else if (adv_i) begin
      base_o <= base_o + (N_W+1)'(WARP_SZ);
      if (warp_o == wlast_i) begin
        warp_o <= '0;
        blk_o  <= blk_o + 1'b1;
        core_o <= (core_o == CORE_LAST) ? '0 : core_o + 1'b1;
      end else begin
        warp_o <= warp_o + 1'b1;
      end
    end
  end

  // R6: each advance moves exactly one warp forward
  a_r6_step_one_warp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> base_o == $past(base_o) + (N_W+1)'(WARP_SZ));

  // R5: core number stays inside the core set
  a_r5_core_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_o <= CORE_LAST);

  // R1: block index only moves on a warp-index wrap
  a_r1_blk_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && (warp_o != wlast_i) |=> $stable(blk_o));
endmodule

// File: rtl/simt_launch_gen.sv
module simt_launch_gen
  import simt_launch_pkg::*;
#(
  parameter int N_W       = 16,
  parameter int MAX_BD    = 512,
  parameter int NUM_CORES = 4,
  parameter int BD_W      = $clog2(MAX_BD) + 1,
  parameter int WI_W      = $clog2(MAX_BD / WARP_SZ),
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_W-1:0]     n_i,
  input  logic [BD_W-1:0]    block_dim_i,
  input  logic               ready_i,
  output logic               busy_o,
  output logic               err_o,
  output logic               valid_o,
  output logic [N_W-1:0]     blk_idx_o,
  output logic [WI_W-1:0]    warp_idx_o,
  output logic [N_W-1:0]     base_idx_o,
  output logic [WARP_SZ-1:0] mask_o,
  output logic [CORE_W-1:0]  core_o
);
  launch_st_e      st_q;
  logic [N_W-1:0]  n_q;
  logic [WI_W-1:0] wlast_q;
  logic            err_q;
  logic            cfg_ok;
  logic [WI_W-1:0] cfg_wlast;
  logic            accept, go, fire, last;
  logic [N_W:0]    base;

  launch_cfg_check #(.MAX_BD(MAX_BD), .BD_W(BD_W), .WI_W(WI_W)) u_cfg (
    .bd_i   (block_dim_i),
    .ok_o   (cfg_ok),
    .wlast_o(cfg_wlast)
  );

  assign accept = start_i && (st_q == ST_IDLE);
  assign go     = accept && cfg_ok && (n_i != '0);
  assign fire   = valid_o && ready_i;

  launch_walker #(.N_W(N_W), .WI_W(WI_W), .NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go),
    .adv_i  (fire && !last),
    .wlast_i(wlast_q),
    .base_o (base),
    .warp_o (warp_idx_o),
    .blk_o  (blk_idx_o),
    .core_o (core_o)
  );

  warp_mask_gen #(.CNT_W(N_W)) u_mask (
    .n_i   (n_q),
    .base_i(base),
    .mask_o(mask_o),
    .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      n_q     <= '0;
      wlast_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept) err_q <= !cfg_ok;
      if (go) begin
        n_q     <= n_i;
        wlast_q <= cfg_wlast;
      end
      unique case (st_q)
        ST_IDLE: if (go) st_q <= ST_RUN;
        ST_RUN:  if (fire && last) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q == ST_RUN);
  assign valid_o    = (st_q == ST_RUN);
  assign err_o      = err_q;
  assign base_idx_o = base[N_W-1:0];

  // R6: held warp does not change under backpressure
  a_r6_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(mask_o) && $stable(base_idx_o)
      && $stable(blk_idx_o) && $stable(warp_idx_o) && $stable(core_o));

  // R4: an emitted warp always has lane 0 enabled
  a_r4_no_empty_warp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> mask_o[0]);

  // R7: error and a running launch never coexist
  a_r7_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  // R8: latched count is frozen while a launch runs
  a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(n_q));

  // R9: busy falls right after the final transfer
  a_r9_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && last |=> !busy_o);
endmodule

// File: tb/simt_launch_gen_bench.sv
module simt_launch_gen_bench;
  localparam int N_W = 16;
  localparam int BD_W = 10;
  localparam int WI_W = 4;
  localparam int NC = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [N_W-1:0] n_i = '0;
  logic [BD_W-1:0] block_dim_i = '0;
  logic ready_i = 1'b0;
  logic busy_o, err_o, valid_o;
  logic [N_W-1:0] blk_idx_o, base_idx_o;
  logic [WI_W-1:0] warp_idx_o;
  logic [31:0] mask_o;
  logic [CW-1:0] core_o;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  simt_launch_gen u_simt_launch_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .n_i(n_i),
    .block_dim_i(block_dim_i), .ready_i(ready_i), .busy_o(busy_o),
    .err_o(err_o), .valid_o(valid_o), .blk_idx_o(blk_idx_o),
    .warp_idx_o(warp_idx_o), .base_idx_o(base_idx_o), .mask_o(mask_o),
    .core_o(core_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // mode 0: ready always high; mode 1: ready low every third cycle
  task automatic run_launch(input int n, input int bd, input int mode, input bit poke);
    int exp_g = 0;
    int cyc = 0;
    int maxblk = -1;
    bit done = 0;
    bit held = 0;
    logic [N_W-1:0] s_blk, s_base;
    logic [WI_W-1:0] s_w;
    logic [31:0] s_mask;
    logic [CW-1:0] s_core;
    @(negedge clk);
    start_i = 1'b1; n_i = N_W'(n); block_dim_i = BD_W'(bd);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == (n > 0), "R9", "busy after start", busy_o, n > 0);
    chk(err_o == 1'b0, "R7", "err after legal start", err_o, 0);
    while (!done && cyc < 5000) begin
      if (!valid_o) begin
        chk(exp_g >= n, "R4", "warps emitted", exp_g, n);
        chk(busy_o == 1'b0, "R9", "busy at end", busy_o, 0);
        done = 1;
      end else if (exp_g >= n) begin
        chk(0, "R4", "extra warp base", base_idx_o, n);
        done = 1;
      end else begin
        bit rdy;
        logic [31:0] em;
        int eb;
        if (held) begin
          chk(mask_o == s_mask && base_idx_o == s_base && blk_idx_o == s_blk &&
              warp_idx_o == s_w && core_o == s_core, "R6", "hold under stall",
              base_idx_o, s_base);
        end
        rdy = (mode == 0) ? 1'b1 : ((cyc % 3) != 2);
        ready_i = rdy;
        if (poke && cyc == 1) begin
          start_i = 1'b1; n_i = 16'd5; block_dim_i = 10'd32;
        end
        if (rdy) begin
          eb = exp_g / bd;
          for (int i = 0; i < 32; i++) em[i] = (exp_g + i) < n;
          chk(blk_idx_o == N_W'(eb), "R1", "block index", blk_idx_o, eb);
          chk(base_idx_o == N_W'(exp_g), "R2", "base index", base_idx_o, exp_g);
          chk(warp_idx_o == WI_W'((exp_g % bd) / 32), "R2", "warp index",
              warp_idx_o, (exp_g % bd) / 32);
          chk(mask_o == em, "R3", "mask", mask_o, em);
          chk(core_o == CW'(eb % NC), "R5", "core", core_o, eb % NC);
          if (eb > maxblk) maxblk = eb;
          exp_g += 32;
          held = 0;
        end else begin
          held = 1;
          s_mask = mask_o; s_base = base_idx_o; s_blk = blk_idx_o;
          s_w = warp_idx_o; s_core = core_o;
        end
        @(negedge clk);
        start_i = 1'b0;
        ready_i = 1'b0;
        cyc++;
      end
    end
    chk(maxblk + 1 == (n + bd - 1) / bd, "R1", "block count", maxblk + 1, (n + bd - 1) / bd);
  endtask

  task automatic run_bad(input int bd);
    @(negedge clk);
    start_i = 1'b1; n_i = 16'd100; block_dim_i = BD_W'(bd);
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R7", "err on illegal size", err_o, 1);
    chk(busy_o == 1'b0 && valid_o == 1'b0, "R7", "no launch on illegal size", busy_o, 0);
  endtask

  task automatic run_reset;
    #1;
    chk(busy_o == 0 && valid_o == 0 && err_o == 0, "R10", "reset state",
        {busy_o, valid_o, err_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    run_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    run_launch(0, 256, 0, 0);     // R4: empty launch
    run_launch(1000, 256, 0, 0);  // partial last warp
    run_launch(1280, 256, 1, 0);  // R5: core wrap on exact block edge, stalls
    run_launch(1290, 256, 1, 1);  // R8: start poked while busy; wrap plus partial
    run_launch(70, 64, 1, 0);     // R4: empty tail warp skipped
    run_launch(600, 512, 0, 0);   // largest block size
    run_launch(100, 32, 1, 0);    // one warp per block
    run_bad(48);
    run_bad(0);
    run_bad(544);
    run_launch(33, 96, 0, 0);     // R7: clears err
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule